// File: doc/BRIEF.md
# Timekeeping Register Write Gate

This block decides, in the same cycle as a register-bus write, which register of a timekeeping bank may take that write. A lock sits in front of the bank. Software opens the lock by writing a two-byte key, in order, to a dedicated key register. The lock closes again on any byte that breaks the sequence.

The lock is cleared only by the power-on reset. A system reset leaves it as it was. While the system reset is held, bus writes are ignored.

Several registers also need a second condition besides the open lock. For some it is the initialization-mode flag. For others it is a flag from the register's own clock domain, saying the register is ready to be written or that an update is still pending. A few registers and fields are never gated. The block drives one write-enable bit per register, plus two field enables for the registers that are split into gated and ungated parts.

Top module: `rtc_wr_gate`

## Requirements
- R1: After power-on reset the lock is closed. Every lock-gated enable stays low until the full key has been written. Asserting the power-on reset while the lock is open closes it.
- R2: While `sys_rst_n` is low, no enable is raised and a key-register write has no effect. Holding the system reset does not change the lock state.
- R3: The lock opens on the clock edge that takes a write of 0x53 to the key register (address 5), provided the previous key-register write was 0xCA. Gated registers may be written from the next cycle on.
- R4: Writing 0xCA to the key register from any state arms the sequence but leaves the lock closed. Any other byte closes the lock, except 0x53 written directly after 0xCA. This includes 0x53 written while locked and 0x53 written while already open.
- R5: Writes to any address other than the key register do not disturb the key sequence. This includes addresses that decode to no register.
- R6: The time (address 2), date (address 3) and prescaler (address 4) registers are enabled only when the lock is open and `init_mode` is 1.
- R7: For the control register (address 0), `reg_we[0]` requires only the open lock. `ctrl_init_we`, which covers its two initialization-only bits, requires the open lock and `init_mode`.
- R8: For the status register (address 1), `stat_free_we` is raised on every write, so its free field is always writable. `reg_we[1]` requires the open lock.
- R9: The wakeup reload register (address 7) requires the open lock and `wake_ok`. The alarm register (address 8) and alarm-subsecond register (address 9) require the open lock and `alarm_ok`.
- R10: The time-adjust register (address 10) requires the open lock and `adj_busy` low. The calibration register (address 11) requires the open lock and `cal_busy` low.
- R11: The key register (5), subsecond (6), the three timestamp registers (12 to 14), tamper configuration (15) and the backup registers (16 and up) are enabled on every write, whatever the lock state.
- R12: Each enable is high only during the cycle of a write to its own address, so at most one `reg_we` bit is high at a time. Addresses at or above 16 plus the backup count raise no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, active low; blocks bus writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register index of the write |
| wr_byte | input | 8 | Low byte of the write data |
| init_mode | input | 1 | Initialization mode is active |
| wake_ok | input | 1 | Wakeup reload register may be written |
| alarm_ok | input | 1 | Alarm registers may be written |
| adj_busy | input | 1 | Time adjustment still pending |
| cal_busy | input | 1 | Calibration update still pending |
| reg_we | output | NREG | Write enable per register (gated part) |
| ctrl_init_we | output | 1 | Enable for the control bits that need initialization mode |
| stat_free_we | output | 1 | Enable for the always-writable status field |

## Verification
The hardest states to reach are an open lock that is then disturbed. Examples are a second 0x53 while open, a fresh 0xCA while open, a system reset held while open, and foreign writes placed between the two key bytes. Random traffic almost never forms the key pair by chance.

The stimulus therefore runs directed sequences first. It then biases random traffic toward the key address and the two key bytes, so the lock opens and closes hundreds of times. Meanwhile the readiness flags and the mode flag toggle independently, so every gated register is seen with its qualifier both set and clear while the lock is open.

// File: rtl/rtc_gate_pkg.sv
package rtc_gate_pkg;

    // Register indices inside the timekeeping bank
    localparam int unsigned IDX_CTRL      = 0;
    localparam int unsigned IDX_STAT      = 1;
    localparam int unsigned IDX_TIME      = 2;
    localparam int unsigned IDX_DATE      = 3;
    localparam int unsigned IDX_PRESC     = 4;
    localparam int unsigned IDX_KEY       = 5;
    localparam int unsigned IDX_SUBSEC    = 6;
    localparam int unsigned IDX_WAKE      = 7;
    localparam int unsigned IDX_ALARM     = 8;
    localparam int unsigned IDX_ALARM_SUB = 9;
    localparam int unsigned IDX_ADJ       = 10;
    localparam int unsigned IDX_CAL       = 11;
    localparam int unsigned IDX_TS_TIME   = 12;
    localparam int unsigned IDX_TS_DATE   = 13;
    localparam int unsigned IDX_TS_SUB    = 14;
    localparam int unsigned IDX_TAMPER    = 15;
    localparam int unsigned IDX_BKP0      = 16;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    // Write permission class of a register
    typedef enum logic [2:0] {
        POL_FREE,
        POL_LOCK,
        POL_LOCK_INIT,
        POL_LOCK_WAKE,
        POL_LOCK_ALARM,
        POL_LOCK_ADJ,
        POL_LOCK_CAL
    } policy_e;

    function automatic policy_e policy_of(input int unsigned idx);
        policy_e p;
        case (idx)
            IDX_CTRL, IDX_STAT:                p = POL_LOCK;
            IDX_TIME, IDX_DATE, IDX_PRESC:     p = POL_LOCK_INIT;
            IDX_WAKE:                          p = POL_LOCK_WAKE;
            IDX_ALARM, IDX_ALARM_SUB:          p = POL_LOCK_ALARM;
            IDX_ADJ:                           p = POL_LOCK_ADJ;
            IDX_CAL:                           p = POL_LOCK_CAL;
            default:                           p = POL_FREE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rtc_gate_key_seq.sv
module rtc_gate_key_seq
    import rtc_gate_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'hCA,
    parameter logic [7:0] KEY_B = 8'h53
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlocked
);

    typedef struct packed {
        key_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (key_wr) begin
            if (key_byte == KEY_A) begin
                seq_d.st = KS_ARMED;
            end else if (seq_q.st == KS_ARMED && key_byte == KEY_B) begin
                seq_d.st = KS_OPEN;
            end else begin
                seq_d.st = KS_LOCKED;
            end
        end
    end

    // Only the power-on reset clears the lock
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q <= '{st: KS_LOCKED};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign unlocked = (seq_q.st == KS_OPEN);

endmodule

// File: rtl/rtc_gate_decode.sv
module rtc_gate_decode #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NREG   = 26
) (
    input  logic              wr_live,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NREG-1:0]   hit
);

    // NREG must not exceed 2**ADDR_W; addresses beyond NREG hit nothing
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = wr_live && (wr_addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rtc_gate_policy.sv
module rtc_gate_policy
    import rtc_gate_pkg::*;
#(
    parameter int unsigned NREG = 26
) (
    input  logic [NREG-1:0] hit,
    input  logic            unlocked,
    input  logic            init_mode,
    input  logic            wake_ok,
    input  logic            alarm_ok,
    input  logic            adj_busy,
    input  logic            cal_busy,
    output logic [NREG-1:0] we
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam policy_e P = policy_of(i);
        logic allow;
        if (P == POL_FREE) begin : g_free
            assign allow = 1'b1;
        end else if (P == POL_LOCK) begin : g_lock
            assign allow = unlocked;
        end else if (P == POL_LOCK_INIT) begin : g_init
            assign allow = unlocked && init_mode;
        end else if (P == POL_LOCK_WAKE) begin : g_wake
            assign allow = unlocked && wake_ok;
        end else if (P == POL_LOCK_ALARM) begin : g_alarm
            assign allow = unlocked && alarm_ok;
        end else if (P == POL_LOCK_ADJ) begin : g_adj
            assign allow = unlocked && !adj_busy;
        end else begin : g_cal
            assign allow = unlocked && !cal_busy;
        end
        assign we[i] = hit[i] && allow;
    end

endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
    import rtc_gate_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned NUM_BKP = 10,
    parameter logic [7:0]  KEY_A   = 8'hCA,
    parameter logic [7:0]  KEY_B   = 8'h53
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     sys_rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_byte,
    input  logic                     init_mode,
    input  logic                     wake_ok,
    input  logic                     alarm_ok,
    input  logic                     adj_busy,
    input  logic                     cal_busy,
    output logic [IDX_BKP0+NUM_BKP-1:0] reg_we,
    output logic                     ctrl_init_we,
    output logic                     stat_free_we
);

    localparam int unsigned NREG = IDX_BKP0 + NUM_BKP;

    logic            wr_live;
    logic [NREG-1:0] hit;
    logic            unlocked;

    // The bus is held off while the system reset is asserted
    assign wr_live = wr_en && sys_rst_n;

    rtc_gate_decode #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_decode (
        .wr_live (wr_live),
        .wr_addr (wr_addr),
        .hit     (hit)
    );

    rtc_gate_key_seq #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_key (
        .clk      (clk),
        .por_n    (por_n),
        .key_wr   (hit[IDX_KEY]),
        .key_byte (wr_byte),
        .unlocked (unlocked)
    );

    rtc_gate_policy #(
        .NREG (NREG)
    ) u_policy (
        .hit       (hit),
        .unlocked  (unlocked),
        .init_mode (init_mode),
        .wake_ok   (wake_ok),
        .alarm_ok  (alarm_ok),
        .adj_busy  (adj_busy),
        .cal_busy  (cal_busy),
        .we        (reg_we)
    );

    // Field enables of the two split registers
    assign ctrl_init_we = hit[IDX_CTRL] && unlocked && init_mode;
    assign stat_free_we = hit[IDX_STAT];

endmodule

// File: rtl/rtc_wr_gate_chk.sv
module rtc_wr_gate_chk
    import rtc_gate_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NREG   = 26,
    parameter logic [7:0]  KEY_A  = 8'hCA,
    parameter logic [7:0]  KEY_B  = 8'h53
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_byte,
    input logic              init_mode,
    input logic              wake_ok,
    input logic              alarm_ok,
    input logic              adj_busy,
    input logic              cal_busy,
    input logic [NREG-1:0]   reg_we,
    input logic              ctrl_init_we,
    input logic              stat_free_we,
    input logic              unlocked
);

    logic key_wr;
    assign key_wr = wr_en && sys_rst_n && (wr_addr == ADDR_W'(IDX_KEY));

    // R1
    por_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> !unlocked);

    // R2
    sysrst_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |-> (reg_we == '0) && !ctrl_init_we && !stat_free_we);

    // R2
    sysrst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> $stable(unlocked));

    // R3
    open_after_key_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> $past(key_wr && wr_byte == KEY_B));

    // R4
    bad_key_chk: assert property (@(posedge clk) disable iff (!por_n)
        (key_wr && wr_byte != KEY_A && wr_byte != KEY_B) |=> !unlocked);

    // R6
    time_init_chk: assert property (@(posedge clk) disable iff (!por_n)
        reg_we[IDX_TIME] |-> unlocked && init_mode);

    // R7
    ctrl_init_chk: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_init_we |-> reg_we[IDX_CTRL] && init_mode);

    // R9
    wake_ok_chk: assert property (@(posedge clk) disable iff (!por_n)
        reg_we[IDX_WAKE] |-> unlocked && wake_ok);

    // R10
    adj_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        reg_we[IDX_ADJ] |-> unlocked && !adj_busy);

    // R11
    tamper_free_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && sys_rst_n && wr_addr == ADDR_W'(IDX_TAMPER)) |-> reg_we[IDX_TAMPER]);

    // R12
    single_we_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(reg_we));

endmodule

bind rtc_wr_gate rtc_wr_gate_chk #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .KEY_A  (KEY_A),
    .KEY_B  (KEY_B)
) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst_n    (sys_rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_byte      (wr_byte),
    .init_mode    (init_mode),
    .wake_ok      (wake_ok),
    .alarm_ok     (alarm_ok),
    .adj_busy     (adj_busy),
    .cal_busy     (cal_busy),
    .reg_we       (reg_we),
    .ctrl_init_we (ctrl_init_we),
    .stat_free_we (stat_free_we),
    .unlocked     (unlocked)
);

// File: tb/test_rtc_wr_gate.sv
`timescale 1ns/1ps
module test_rtc_wr_gate;

    localparam int ADDR_W = 5;
    localparam int NREG   = 26;
    localparam int OUT_W  = NREG + 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sys_rst_n = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_byte = '0;
    logic init_mode = 1'b0, wake_ok = 1'b0, alarm_ok = 1'b0;
    logic adj_busy = 1'b0, cal_busy = 1'b0;
    logic [NREG-1:0] reg_we;
    logic ctrl_init_we, stat_free_we;

    int checks = 0;
    int errors = 0;
    int ms = 0; // model: 0 locked, 1 armed, 2 open

    always #2.5 clk = ~clk;

    rtc_wr_gate i_rtc_wr_gate (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_byte(wr_byte), .init_mode(init_mode),
        .wake_ok(wake_ok), .alarm_ok(alarm_ok), .adj_busy(adj_busy),
        .cal_busy(cal_busy), .reg_we(reg_we), .ctrl_init_we(ctrl_init_we),
        .stat_free_we(stat_free_we)
    );

    // Expected {ctrl_init_we, stat_free_we, reg_we}
    function automatic logic [OUT_W-1:0] exp_out(input int a, input bit live);
        logic [NREG-1:0] v = '0;
        bit u = (ms == 2);
        bit ok;
        bit ci = 0, sf = 0;
        if (!live || a >= NREG) return '0;
        case (a)
            0, 1:     ok = u;
            2, 3, 4:  ok = u && init_mode;
            7:        ok = u && wake_ok;
            8, 9:     ok = u && alarm_ok;
            10:       ok = u && !adj_busy;
            11:       ok = u && !cal_busy;
            default:  ok = 1;
        endcase
        v[a] = ok;
        if (a == 0) ci = u && init_mode;
        if (a == 1) sf = 1;
        return {ci, sf, v};
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0:           return "R7";
            1:           return "R8";
            2, 3, 4:     return "R6";
            7, 8, 9:     return "R9";
            10, 11:      return "R10";
            default:     return (a >= NREG) ? "R12" : "R11";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [OUT_W-1:0] exp);
        logic [OUT_W-1:0] got = {ctrl_init_we, stat_free_we, reg_we};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h time=%0t", tag, got, exp, $time);
        end
    endtask

    // One bus write; outputs are checked in the low phase before the edge
    task automatic wr(input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_byte = d;
        #1;
        compare(tag, exp_out(a, sys_rst_n));
        @(posedge clk);
        if (sys_rst_n && a == 5) begin
            if (d == 8'hCA) ms = 1;
            else if (ms == 1 && d == 8'h53) ms = 2;
            else ms = 0;
        end
        #0.5;
        wr_en = 1'b0;
    endtask

    // Lock probe through the time register with init mode on
    task automatic probe(input string tag);
        init_mode = 1'b1;
        wr(2, 8'h00, tag);
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); ms = 0; por_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        do_por();

        // R12: idle, no enables
        @(negedge clk); #1; compare("R12 idle", '0);
        probe("R1 locked after power-on");

        // R3 / R4: unlock sequence
        wr(5, 8'hCA, "R11 key write");
        probe("R3 armed still locked");
        wr(5, 8'h53, "R11 key write");
        probe("R3 open");
        wr(5, 8'h53, "R11 key write");
        probe("R4 second 0x53 relocks");
        wr(5, 8'h53, "R11 key write");
        probe("R4 lone 0x53 keeps locked");
        wr(5, 8'hCA, "R11"); wr(5, 8'hCA, "R11"); wr(5, 8'h53, "R11");
        probe("R4 double 0xCA then 0x53 opens");
        wr(5, 8'hCA, "R11");
        probe("R4 0xCA while open closes");

        // R5: foreign writes between key bytes
        wr(5, 8'hCA, "R11"); probe("R5 probe between"); wr(31, 8'h53, "R12 unmapped");
        wr(14, 8'h00, "R11"); wr(5, 8'h53, "R11");
        probe("R5 sequence intact");

        // R2: system reset holds lock and blocks writes
        @(negedge clk); sys_rst_n = 1'b0;
        wr(5, 8'h00, "R2 key ignored");
        wr(15, 8'h00, "R2 free write blocked");
        @(negedge clk); sys_rst_n = 1'b1;
        probe("R2 lock kept over system reset");

        // Policy sweep with lock open and closed
        for (int pass = 0; pass < 4; pass++) begin
            init_mode = pass[0]; wake_ok = pass[0]; alarm_ok = pass[1];
            adj_busy = pass[0]; cal_busy = pass[1];
            for (int a = 0; a < 32; a++) if (a != 5) wr(a, 8'h11, tag_of(a));
        end
        do_por();
        probe("R1 power-on reset closes open lock");
        for (int a = 0; a < NREG; a++) if (a != 5) wr(a, 8'h22, tag_of(a));

        // Constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            int a;
            logic [7:0] d;
            int r = int'($urandom_range(0, 99));
            init_mode = 1'($urandom); wake_ok = 1'($urandom);
            alarm_ok = 1'($urandom); adj_busy = 1'($urandom);
            cal_busy = 1'($urandom);
            sys_rst_n = ($urandom_range(0, 29) != 0);
            a = (r < 35) ? 5 : int'($urandom_range(0, 31));
            r = int'($urandom_range(0, 9));
            d = (r < 4) ? 8'hCA : (r < 8) ? 8'h53 : 8'($urandom);
            wr(a, d, (a == 5) ? "R4 random key" :
                     (sys_rst_n == 1'b0) ? "R2 random" : tag_of(a));
            if ($urandom_range(0, 99) == 0) begin
                do_por();
                probe("R1 random power-on");
            end
        end
        sys_rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule